// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block is the bus master that erases every byte of a byte-wide flash array and proves the erase worked. A `start` pulse begins the run. The block raises the high-voltage supply enable. It then asks a separate program sequencer, over a request/acknowledge pair, to bring every byte to 00h. Only then does it begin erasing. Each erase pulse is two back-to-back command writes of 20h, followed by a timed wait.

After each pulse the block checks bytes one at a time, starting at the address it has reached so far. For each byte it writes the verify command A0h together with the byte address, waits a short settling time, and reads the byte back. A byte that reads FFh passes, and the walk moves to the next address. A byte that reads anything else triggers another erase pulse, and the check resumes at that same address rather than going back to zero.

A run ends in one of three ways: the last address passes, the pulse budget is used up, or the pre-program step reports an error. In every case the block writes the read-mode command 00h, drops the supply enable and pulses `done`, with `fail` showing the result.

Top module: `flash_erase_seq`

## Requirements
- R1: After `start`, `pp_req` rises and stays high until `pp_ack` is seen. No erase command (20h) is written before that acknowledge.
- R2: An erase pulse is two writes of 20h on consecutive cycles. The next write (A0h) happens exactly ERASE_CYC+1 cycles after the second 20h write.
- R3: A verify writes A0h with the byte's address on `fl_addr`. Exactly VFY_CYC+1 cycles later a read strobe occurs at the same address. The byte passes only if it returns FFh. `fl_we_n` and `fl_oe_n` are never low together.
- R4: The verify walk starts at address 0 and advances by one after each passing byte. When all bytes pass with one pulse, the reads cover addresses 0 through 2^ADDR_W-1 in order, and the run ends with `fail` = 0.
- R5: When a byte fails, the block issues another erase pulse. The first verify after that pulse uses the failing address, and the walk continues upward from there.
- R6: If a byte still fails after MAX_PULSES erase pulses, the run ends with `fail` = 1. No further pulse is issued.
- R7: `fl_vpp_en` is high on every flash bus cycle of a run and low in the cycle after `done`.
- R8: The last write of every run is 00h, and it is made in the cycle where `done` is high.
- R9: If `pp_err` is high along with `pp_ack`, the run ends with `fail` = 1 and no erase pulse at all.
- R10: `done` is high for exactly one cycle per run. `fail` keeps its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a chip erase (taken only when idle) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last run, 1 = failed |
| pp_req | output | 1 | Request to the program sequencer to write 00h everywhere |
| pp_ack | input | 1 | Program sequencer finished |
| pp_err | input | 1 | Program sequencer failed, valid with `pp_ack` |
| fl_we_n | output | 1 | Flash write strobe, active low, one cycle per write |
| fl_oe_n | output | 1 | Flash read strobe, active low, data sampled at the end of the cycle |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq | inout | 8 | Flash data bus, driven only while `fl_we_n` is low |
| fl_vpp_en | output | 1 | High-voltage supply enable |

## Verification
All flash strobes are decoded straight from the state register, so each bus cycle is visible in the same cycle the state is entered. The program acknowledge affects the bus one cycle later. The A0h write follows the second 20h write by ERASE_CYC+1 cycles, and the verify read follows the A0h write by VFY_CYC+1 cycles. `done` appears together with the final 00h write, and the supply enable falls one cycle after that. The bench watches the bus at the falling clock edge, halfway between the edges where the state changes. It time-stamps every write and read with a cycle counter, compares the gaps with these exact values, and reads the end result one falling edge after `done`.

// File: rtl/fes_pkg.sv
// Package: shared state encoding and command bytes for the chip-erase sequencer.
package fes_pkg;
    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] ERASED_VAL = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREPROG,
        ST_ER_ARM,
        ST_ER_FIRE,
        ST_ER_WAIT,
        ST_VF_ARM,
        ST_VF_WAIT,
        ST_VF_READ,
        ST_WRAPUP
    } fes_state_t;
endpackage

// File: rtl/fes_timer.sv
// Module: fes_timer
// Down-counter used for the erase-pulse and verify-settle waits.
// Assumes: load has priority; zero is high whenever the count is 0.
module fes_timer #(
    parameter int MAX_CYC = 1250000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [$clog2(MAX_CYC+1)-1:0]  load_val,
    output logic                          zero
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fes_addr_walk.sv
// Module: fes_addr_walk
// Holds the verify address. It is cleared at start, kept when a byte fails,
// and stepped up by one when a byte passes.
// Assumes: inc is never requested at the last address.
module fes_addr_walk #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              is_last
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    // Clear at run start, step on a passing byte, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign is_last = (addr == LAST);
endmodule

// File: rtl/fes_pulse_ctr.sv
// Module: fes_pulse_ctr
// Counts erase pulses issued in the current run and flags the budget limit.
// Assumes: inc is never requested once at_cap is high.
module fes_pulse_ctr #(
    parameter int MAX_PULSES = 1000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             inc,
    output logic [$clog2(MAX_PULSES+1)-1:0]  count,
    output logic                             at_cap
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] CAP = PW'(MAX_PULSES);

    // Reset per run, increment once per fired erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign at_cap = (count == CAP);
endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq
// Chip-erase bus master. It asks for the pre-program, fires erase pulses
// (20h,20h plus a wait), and walks the erase-verify (A0h, settle, read FFh)
// from address 0. After a failing byte it re-erases and resumes at that
// address. Every run ends with a 00h read-mode write and a done pulse.
// Assumes: one write per cycle and a read sampled at the end of its cycle;
// ERASE_CYC and VFY_CYC are at least 1.
module flash_erase_seq #(
    parameter int ADDR_W     = 17,
    parameter int ERASE_CYC  = 1250000,
    parameter int VFY_CYC    = 750,
    parameter int MAX_PULSES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              fail,
    output logic              pp_req,
    input  logic              pp_ack,
    input  logic              pp_err,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    inout  wire  [7:0]        fl_dq,
    output logic              fl_vpp_en
);
    import fes_pkg::*;

    localparam int TMAX = (ERASE_CYC > VFY_CYC) ? ERASE_CYC : VFY_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(MAX_PULSES + 1);

    fes_state_t       state, nxt;
    logic             fail_q;
    logic             addr_clr, addr_inc, is_last;
    logic             pul_inc, at_cap;
    logic [PW-1:0]    pulse_cnt;
    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic [7:0]       dq_out;
    logic             dq_drv;
    logic             byte_ok;

    fes_timer #(.MAX_CYC(TMAX)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    fes_addr_walk #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
        .addr(fl_addr), .is_last(is_last)
    );

    fes_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pul (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(pul_inc),
        .count(pulse_cnt), .at_cap(at_cap)
    );

    assign byte_ok = (fl_dq == ERASED_VAL);

    // Next-state and control-strobe decode.
    always_comb begin
        nxt      = state;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        pul_inc  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (start) begin
                addr_clr = 1'b1;
                nxt      = ST_PREPROG;
            end
            ST_PREPROG: if (pp_ack)
                nxt = pp_err ? ST_WRAPUP : ST_ER_ARM;
            ST_ER_ARM:  nxt = ST_ER_FIRE;
            ST_ER_FIRE: begin
                pul_inc  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(ERASE_CYC - 1);
                nxt      = ST_ER_WAIT;
            end
            ST_ER_WAIT: if (tmr_zero) nxt = ST_VF_ARM;
            ST_VF_ARM: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(VFY_CYC - 1);
                nxt      = ST_VF_WAIT;
            end
            ST_VF_WAIT: if (tmr_zero) nxt = ST_VF_READ;
            ST_VF_READ: begin
                if (byte_ok) begin
                    if (is_last) nxt = ST_WRAPUP;
                    else begin
                        addr_inc = 1'b1;
                        nxt      = ST_VF_ARM;
                    end
                end else begin
                    nxt = at_cap ? ST_WRAPUP : ST_ER_ARM;
                end
            end
            ST_WRAPUP: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Result flag: cleared at start, set on pre-program error or pulse budget exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_q <= 1'b0;
        else if (state == ST_IDLE && start)
            fail_q <= 1'b0;
        else if (state == ST_PREPROG && pp_ack && pp_err)
            fail_q <= 1'b1;
        else if (state == ST_VF_READ && !byte_ok && at_cap)
            fail_q <= 1'b1;
    end

    // Bus decode: write strobe and command byte, read strobe, supply enable.
    always_comb begin
        dq_drv = 1'b1;
        dq_out = CMD_READ;
        case (state)
            ST_ER_ARM, ST_ER_FIRE: dq_out = CMD_ERASE;
            ST_VF_ARM:             dq_out = CMD_VERIFY;
            ST_WRAPUP:             dq_out = CMD_READ;
            default:               dq_drv = 1'b0;
        endcase
    end

    assign fl_we_n   = ~dq_drv;
    assign fl_oe_n   = (state != ST_VF_READ);
    assign fl_dq     = dq_drv ? dq_out : 8'hzz;
    assign fl_vpp_en = (state != ST_IDLE);
    assign pp_req    = (state == ST_PREPROG);
    assign done      = (state == ST_WRAPUP);
    assign fail      = fail_q;
endmodule

// File: rtl/fes_chk.sv
// Module: fes_chk
// Checker bound to flash_erase_seq: bus, handshake and pulse-budget properties.
// Assumes: the same clock and synchronous active-low reset as the design.
module fes_chk #(
    parameter int MAX_PULSES = 1000
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            done,
    input logic                            we_n,
    input logic                            oe_n,
    input logic                            vpp_en,
    input logic                            pp_req,
    input logic                            pp_ack,
    input logic [$clog2(MAX_PULSES+1)-1:0] pulses
);
    // R3: the two strobes never overlap.
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    // R7: the supply is on during every flash bus cycle.
    p_vpp_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> vpp_en);

    // R7: the supply is off right after completion.
    p_vpp_off_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !vpp_en);

    // R10: done lasts one cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: the pre-program request holds until acknowledged.
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_req && !pp_ack) |=> pp_req);

    // R6: the pulse count never exceeds the budget.
    p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pulses) <= MAX_PULSES);
endmodule

bind flash_erase_seq fes_chk #(.MAX_PULSES(MAX_PULSES)) u_fes_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .vpp_en(fl_vpp_en), .pp_req(pp_req), .pp_ack(pp_ack), .pulses(pulse_cnt)
);

// File: tb/sim_flash_erase_seq.sv
// Bench for flash_erase_seq: directed scenarios with a behavioural array
// (per-byte count of pulses still needed) and a program-sequencer stand-in.
module sim_flash_erase_seq;
    localparam int AW   = 4;
    localparam int NB   = 1 << AW;
    localparam int ECYC = 5;
    localparam int VCYC = 3;
    localparam int MAXP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, fail, pp_req, we_n, oe_n, vpp_en;
    logic pp_ack = 1'b0;
    logic pp_err = 1'b0;
    logic [AW-1:0] addr;
    tri   [7:0] dq;

    always #4 clk = ~clk;   // 125 MHz

    flash_erase_seq #(.ADDR_W(AW), .ERASE_CYC(ECYC), .VFY_CYC(VCYC),
                      .MAX_PULSES(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
        .pp_req(pp_req), .pp_ack(pp_ack), .pp_err(pp_err),
        .fl_we_n(we_n), .fl_oe_n(oe_n), .fl_addr(addr), .fl_dq(dq),
        .fl_vpp_en(vpp_en)
    );

    // array model: a byte reads FFh once its remaining pulse count is zero
    int  resist [NB];
    assign dq = !oe_n ? ((resist[addr] == 0) ? 8'hFF : 8'h00) : 8'hzz;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int err_mode = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    int  pulses, reads, pp_seen, prev20, go_cyc, a0_cyc, last_wr, bus_vpp_bad;
    int  early20, wrong_gap_e, wrong_gap_v, rd_addr_bad, a0_addr;
    int  first_after [8];
    int  pend_first;
    int  rd_log [64];
    int  last_was_go;

    task automatic clear_log();
        pulses = 0; reads = 0; pp_seen = 0; prev20 = 0; last_wr = -1;
        bus_vpp_bad = 0; early20 = 0; wrong_gap_e = 0; wrong_gap_v = 0;
        rd_addr_bad = 0; pend_first = 0; last_was_go = 0; a0_addr = -1;
        for (int i = 0; i < 8; i++) first_after[i] = -1;
    endtask

    // program-sequencer stand-in: acknowledge three cycles after request
    int pp_cnt = 0;
    always @(negedge clk) begin
        pp_ack <= 1'b0;
        if (pp_req && !pp_ack) begin
            pp_cnt = pp_cnt + 1;
            if (pp_cnt == 3) begin
                pp_ack  <= 1'b1;
                pp_err  <= (err_mode != 0);
                pp_cnt  = 0;
                pp_seen = 1;
            end
        end
    end

    // bus monitor at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if ((!we_n || !oe_n) && !vpp_en) bus_vpp_bad++;
        if (!we_n) begin
            last_wr = int'(dq);
            if (dq == 8'h20 && !pp_seen) early20++;
            if (dq == 8'hA0) begin
                if (last_was_go && cyc - go_cyc != ECYC + 1) wrong_gap_e++;
                a0_cyc = cyc; a0_addr = int'(addr);
                if (pend_first) begin
                    if (pulses < 8) first_after[pulses] = int'(addr);
                    pend_first = 0;
                end
            end
            last_was_go = 0;
            if (dq == 8'h20 && prev20) begin
                pulses++;
                for (int i = 0; i < NB; i++) if (resist[i] > 0) resist[i]--;
                go_cyc = cyc; prev20 = 0; last_was_go = 1; pend_first = 1;
            end else begin
                prev20 = (dq == 8'h20);
            end
        end
        if (!oe_n) begin
            if (cyc - a0_cyc != VCYC + 1) wrong_gap_v++;
            if (int'(addr) != a0_addr) rd_addr_bad++;
            if (reads < 64) rd_log[reads] = int'(addr);
            reads++;
        end
    end

    task automatic run_once(output int dcyc);
        clear_log();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        dcyc = cyc;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(done == 0, "R10 reset done", int'(done), 0);
        chk(vpp_en == 0 && we_n == 1 && oe_n == 1, "R7 reset bus idle",
            int'({vpp_en, we_n, oe_n}), 3);
        chk(pp_req == 0, "R1 reset req", int'(pp_req), 0);
    endtask

    task automatic t_clean_pass();
        int d, ok;
        for (int i = 0; i < NB; i++) resist[i] = 1;
        err_mode = 0;
        run_once(d);
        chk(early20 == 0, "R1 no erase before ack", early20, 0);
        chk(pulses == 1, "R2 one erase pulse", pulses, 1);
        chk(wrong_gap_e == 0, "R2 pulse gap", wrong_gap_e, 0);
        chk(wrong_gap_v == 0 && rd_addr_bad == 0, "R3 verify timing/address",
            wrong_gap_v + rd_addr_bad, 0);
        ok = (reads == NB);
        for (int i = 0; i < NB && ok; i++) if (rd_log[i] != i) ok = 0;
        chk(ok == 1, "R4 ordered walk", reads, NB);
        chk(fail == 0, "R4 pass result", int'(fail), 0);
        chk(last_wr == 0, "R8 final read command", last_wr, 0);
        chk(vpp_en == 0 && bus_vpp_bad == 0, "R7 supply", bus_vpp_bad, 0);
        chk(done == 0, "R10 done single cycle", int'(done), 0);
    endtask

    task automatic t_resume();
        int d;
        for (int i = 0; i < NB; i++) resist[i] = 1;
        resist[5] = 2; resist[11] = 3;
        run_once(d);
        chk(pulses == 3, "R5 pulse count", pulses, 3);
        chk(first_after[2] == 5, "R5 resume at failing byte", first_after[2], 5);
        chk(first_after[3] == 11, "R5 resume second", first_after[3], 11);
        chk(reads == 6 + 7 + 5, "R5 total reads", reads, 18);
        chk(fail == 0, "R5 pass result", int'(fail), 0);
        chk(wrong_gap_e == 0 && wrong_gap_v == 0, "R3 gaps after re-erase",
            wrong_gap_e + wrong_gap_v, 0);
    endtask

    task automatic t_cap();
        int d;
        for (int i = 0; i < NB; i++) resist[i] = 1;
        resist[3] = 10;
        run_once(d);
        chk(pulses == MAXP, "R6 pulses at cap", pulses, MAXP);
        chk(fail == 1, "R6 fail result", int'(fail), 1);
        chk(last_wr == 0, "R8 read command after fail", last_wr, 0);
        chk(vpp_en == 0, "R7 supply off after fail", int'(vpp_en), 0);
        repeat (5) @(negedge clk);
        chk(fail == 1, "R10 fail held", int'(fail), 1);
    endtask

    task automatic t_pp_err();
        int d;
        for (int i = 0; i < NB; i++) resist[i] = 0;
        err_mode = 1;
        run_once(d);
        err_mode = 0;
        chk(pulses == 0, "R9 no erase pulse", pulses, 0);
        chk(fail == 1, "R9 fail result", int'(fail), 1);
        chk(reads == 0, "R9 no verify", reads, 0);
    endtask

    task automatic t_refail_clears();
        int d;
        for (int i = 0; i < NB; i++) resist[i] = 1;
        run_once(d);
        chk(fail == 0, "R10 fail cleared by new run", int'(fail), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) resist[i] = 0;
        clear_log();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean_pass();
        t_resume();
        t_cap();
        t_pp_err();
        t_refail_clears();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule